// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Condition Flags

This block is a purely combinational 8-bit arithmetic and logic unit. A 4-bit operation code picks one of sixteen functions. The functions act on two byte operands, X and Y. The block returns a byte result together with three condition flags: negative (bit 7 of the result), zero, and out-of-range. It also has a separate divide-by-zero indication.

The out-of-range flag uses a single unsigned rule for every operation. It is raised whenever the exact integer value of the operation lies outside 0..255. Under this rule, a complement, a subtraction that goes below zero, and a left shift that carries out a one all raise it. Division and remainder are unsigned.

The surrounding control logic registers the result and decides whether to keep the flags. This block holds no state.

Top module: `byte_alu`

## Requirements
- R1: Operation codes are OP_NOP=0, OP_ADD=1, OP_SUB=2, OP_MUL=3, OP_DIV=4, OP_MOD=5, OP_INC=6, OP_DEC=7, OP_AND=8, OP_OR=9, OP_XOR=10, OP_NOT=11, OP_SHL=12, OP_SHR=13, OP_ROL=14, OP_ROR=15. OP_NOP yields result 0x00 with zero=1 and the other three flags 0.
- R2: For every operation, flag_sign equals bit 7 of the result, and flag_zero is 1 exactly when the result is 0x00.
- R3: ADD, SUB and MUL return the low 8 bits of the exact sum, difference or product. flag_ovf is 1 exactly when that exact value is below 0 or above 255 (examples: 10+0xFB gives 0x05 with ovf; 0-10 gives 0xF6 with ovf; 0x80*2 gives 0x00 with ovf).
- R4: INC and DEC act on X alone and ignore Y. INC of 0xFF gives 0x00 with ovf=1. DEC of 0x00 gives 0xFF with ovf=1. All other inputs give ovf=0.
- R5: DIV and MOD with a nonzero Y return the unsigned quotient and the unsigned remainder, with ovf=0 (examples: 0xF6/2 gives 0x7B; 10/0xFF gives 0; 0xAC mod 0x10 gives 0x0C).
- R6: DIV or MOD with Y=0x00 drives div_zero=1, result 0x00 and ovf=1. div_zero is 0 for every other operation and operand pair.
- R7: AND, OR and XOR are bitwise and never set ovf.
- R8: NOT returns the bitwise complement of X, ignores Y, and always sets ovf.
- R9: SHL returns X shifted left by one with bit 0 cleared, and sets ovf exactly when bit 7 of X is 1. SHR returns X shifted right by one with bit 7 cleared, and never sets ovf. Both ignore Y.
- R10: ROL moves bit 7 of X into bit 0 (0xF0 gives 0xE1). ROR moves bit 0 into bit 7 (0x0F gives 0x87). Both ignore Y and never set ovf.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| opnd_x | input | 8 | First operand |
| opnd_y | input | 8 | Second operand |
| result | output | 8 | Operation result |
| flag_sign | output | 1 | Bit 7 of result |
| flag_ovf | output | 1 | Exact value outside 0..255, or divide by zero |
| flag_zero | output | 1 | Result is zero |
| div_zero | output | 1 | DIV or MOD with zero divisor |

## Verification
The block holds no state, so every fault appears at the ports in the same evaluation as the stimulus that exposes it; nothing is hidden until a later cycle. A mis-sized carry or borrow shows up only at the byte boundaries, a wrong divider stage shows up only for particular bit patterns of the dividend, and a wrong rotate feed shows up only when the bit that wraps around is set. The operand sweep therefore covers every X against a set of Y values chosen to reach the boundaries and to exercise each divider stage.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opnd_x,
  input  logic [W-1:0] opnd_y,
  output logic [W-1:0] result,
  output logic         flag_sign,
  output logic         flag_ovf,
  output logic         flag_zero,
  output logic         div_zero
);
  localparam logic [3:0] OP_NOP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_MUL = 4'd3;
  localparam logic [3:0] OP_DIV = 4'd4,  OP_MOD = 4'd5,  OP_INC = 4'd6,  OP_DEC = 4'd7;
  localparam logic [3:0] OP_AND = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_NOT = 4'd11;
  localparam logic [3:0] OP_SHL = 4'd12, OP_SHR = 4'd13, OP_ROL = 4'd14, OP_ROR = 4'd15;
  localparam int PW = 2 * W;

  logic [W:0]    sum_w, dif_w, inc_w;
  logic [PW-1:0] prod_w;
  logic [W-1:0]  quo;
  logic [W:0][W-1:0] rem_s;
  logic          y_is_zero, is_divmod;

  assign sum_w  = {1'b0, opnd_x} + {1'b0, opnd_y};
  assign dif_w  = {1'b0, opnd_x} - {1'b0, opnd_y};
  assign inc_w  = {1'b0, opnd_x} + (W+1)'(1);
  assign prod_w = {{W{1'b0}}, opnd_x} * {{W{1'b0}}, opnd_y};

  assign rem_s[0] = '0;
  for (genvar k = 0; k < W; k++) begin : g_div
    logic [W:0] trial;
    logic       fits;
    assign trial        = {rem_s[k], opnd_x[W-1-k]};
    assign fits         = trial >= {1'b0, opnd_y};
    assign quo[W-1-k]   = fits;
    assign rem_s[k+1]   = fits ? W'(trial - {1'b0, opnd_y}) : trial[W-1:0];
  end

  assign y_is_zero = ~|opnd_y;
  assign is_divmod = (op == OP_DIV) || (op == OP_MOD);
  assign div_zero  = is_divmod && y_is_zero;

  always_comb begin
    result   = '0;
    flag_ovf = 1'b0;
    case (op)
      OP_NOP: ;
      OP_ADD: begin result = sum_w[W-1:0]; flag_ovf = sum_w[W]; end
      OP_SUB: begin result = dif_w[W-1:0]; flag_ovf = dif_w[W]; end
      OP_MUL: begin result = prod_w[W-1:0]; flag_ovf = |prod_w[PW-1:W]; end
      OP_DIV: begin
        result   = y_is_zero ? '0 : quo;
        flag_ovf = y_is_zero;
      end
      OP_MOD: begin
        result   = y_is_zero ? '0 : rem_s[W];
        flag_ovf = y_is_zero;
      end
      OP_INC: begin result = inc_w[W-1:0]; flag_ovf = inc_w[W]; end
      OP_DEC: begin result = opnd_x - W'(1); flag_ovf = ~|opnd_x; end
      OP_AND: result = opnd_x & opnd_y;
      OP_OR:  result = opnd_x | opnd_y;
      OP_XOR: result = opnd_x ^ opnd_y;
      OP_NOT: begin result = ~opnd_x; flag_ovf = 1'b1; end
      OP_SHL: begin result = {opnd_x[W-2:0], 1'b0}; flag_ovf = opnd_x[W-1]; end
      OP_SHR: result = {1'b0, opnd_x[W-1:1]};
      OP_ROL: result = {opnd_x[W-2:0], opnd_x[W-1]};
      OP_ROR: result = {opnd_x[0], opnd_x[W-1:1]};
      default: ;
    endcase
  end

  assign flag_sign = result[W-1];
  assign flag_zero = ~|result;
endmodule

module byte_alu_chk #(
  parameter int W = 8
) (
  input logic [3:0]   op,
  input logic [W-1:0] opnd_x,
  input logic [W-1:0] opnd_y,
  input logic [W-1:0] result,
  input logic         flag_sign,
  input logic         flag_ovf,
  input logic         flag_zero,
  input logic         div_zero
);
  always_comb begin
    p_nop_clear_r1: assert (op != 4'd0 || (result == '0 && flag_zero && !flag_ovf && !flag_sign))
      else $error("nop output not cleared");
    p_flag_excl_r2: assert (!(flag_zero && flag_sign))
      else $error("zero and sign both set");
    p_quo_bound_r5: assert (op != 4'd4 || opnd_y == '0 || result <= opnd_x)
      else $error("quotient exceeds dividend");
    p_rem_bound_r5: assert (op != 4'd5 || opnd_y == '0 || result < opnd_y)
      else $error("remainder not below divisor");
    p_dz_forced_r6: assert (!div_zero || (result == '0 && flag_ovf && flag_zero))
      else $error("divide by zero outputs wrong");
    p_logic_noovf_r7: assert (!(op inside {4'd8, 4'd9, 4'd10}) || !flag_ovf)
      else $error("logic op set ovf");
    p_not_disjoint_r8: assert (op != 4'd11 || ((result & opnd_x) == '0 && flag_ovf))
      else $error("not result overlaps operand");
    p_shl_lsb_r9: assert (op != 4'd12 || !result[0])
      else $error("shl lsb not cleared");
    p_rot_pop_r10: assert (!(op inside {4'd14, 4'd15}) || $countones(result) == $countones(opnd_x))
      else $error("rotate changed bit count");
  end
endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
  .op(op), .opnd_x(opnd_x), .opnd_y(opnd_y), .result(result),
  .flag_sign(flag_sign), .flag_ovf(flag_ovf), .flag_zero(flag_zero), .div_zero(div_zero)
);

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] opnd_x = 8'd0, opnd_y = 8'd0;
  logic [7:0] result;
  logic flag_sign, flag_ovf, flag_zero, div_zero;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_alu u_byte_alu (
    .op(op), .opnd_x(opnd_x), .opnd_y(opnd_y), .result(result),
    .flag_sign(flag_sign), .flag_ovf(flag_ovf), .flag_zero(flag_zero), .div_zero(div_zero)
  );

  function automatic logic [7:0] y_pick(int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
      4: return 8'h05;  5: return 8'h0F;  6: return 8'h10;  7: return 8'h33;
      8: return 8'h55;  9: return 8'h7F; 10: return 8'h80; 11: return 8'h81;
      12: return 8'hAA; 13: return 8'hF0; 14: return 8'hFE; default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] c, logic [7:0] y);
    case (c)
      4'd0: return "R1";
      4'd1, 4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return (y == 0) ? "R6" : "R5";
      4'd6, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10: return "R7";
      4'd11: return "R8";
      4'd12, 4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [3:0] c, input logic [7:0] x, input logic [7:0] y);
    int e;
    logic [7:0] er;
    logic eo, ed, es, ez;
    bit bad;
    @(posedge clk);
    op = c; opnd_x = x; opnd_y = y;
    @(negedge clk);
    ed = 0;
    e = 0;
    case (c)
      4'd0: e = 0;
      4'd1: e = int'(x) + int'(y);
      4'd2: e = int'(x) - int'(y);
      4'd3: e = int'(x) * int'(y);
      4'd4: if (y == 0) ed = 1; else e = int'(x) / int'(y);
      4'd5: if (y == 0) ed = 1; else e = int'(x) % int'(y);
      4'd6: e = int'(x) + 1;
      4'd7: e = int'(x) - 1;
      4'd8: e = int'(x & y);
      4'd9: e = int'(x | y);
      4'd10: e = int'(x ^ y);
      4'd11: e = -int'(x) - 1;
      4'd12: e = int'(x) * 2;
      4'd13: e = int'(x) / 2;
      4'd14: e = ((int'(x) * 2) % 256) + int'(x) / 128;
      default: e = int'(x) / 2 + (int'(x) % 2) * 128;
    endcase
    if (ed) begin er = 8'h00; eo = 1; end
    else begin er = 8'(e & 255); eo = (e < 0) || (e > 255); end
    es = er[7];
    ez = (er == 8'h00);
    n_vec++;
    bad = 0;
    if (result !== er || flag_ovf !== eo || div_zero !== ed) begin
      bad = 1;
      $display("FAIL %s op=%0d x=%02h y=%02h: res=%02h ovf=%b dz=%b expected res=%02h ovf=%b dz=%b",
               tag_of(c, y), c, x, y, result, flag_ovf, div_zero, er, eo, ed);
    end
    if (flag_sign !== es || flag_zero !== ez) begin
      bad = 1;
      $display("FAIL R2 op=%0d x=%02h y=%02h: sign=%b zero=%b expected sign=%b zero=%b",
               c, x, y, flag_sign, flag_zero, es, ez);
    end
    if (bad) n_bad++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    // R1 state during reset: NOP inputs, cleared outputs
    @(negedge clk);
    n_vec++;
    if (result !== 8'h00 || flag_zero !== 1'b1 || flag_ovf !== 1'b0 || div_zero !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: res=%02h z=%b o=%b dz=%b expected 00 1 0 0",
               result, flag_zero, flag_ovf, div_zero);
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // directed corner cases
    check(4'd1, 8'd10, 8'hFB);   // R3 add wrap
    check(4'd2, 8'd0, 8'd10);    // R3 borrow
    check(4'd3, 8'h80, 8'd2);    // R3 product overflow
    check(4'd7, 8'h00, 8'h44);   // R4 dec wrap, Y ignored
    check(4'd6, 8'hFF, 8'h02);   // R4 inc wrap
    check(4'd4, 8'hF6, 8'd2);    // R5 unsigned quotient
    check(4'd4, 8'd10, 8'hFF);   // R5 small quotient
    check(4'd5, 8'hAC, 8'h10);   // R5 remainder
    check(4'd4, 8'd5, 8'd0);     // R6 div by zero
    check(4'd5, 8'd5, 8'd0);     // R6 mod by zero
    check(4'd11, 8'hF0, 8'h5A);  // R8 complement, Y ignored
    check(4'd12, 8'h80, 8'h00);  // R9 shl carry out
    check(4'd14, 8'hF0, 8'h33);  // R10 rol
    check(4'd15, 8'h0F, 8'hCC);  // R10 ror

    // sweep: every op, every X, sixteen Y values (R1..R10)
    for (int c = 0; c < 16; c++)
      for (int x = 0; x < 256; x++)
        for (int i = 0; i < 16; i++)
          check(4'(c), 8'(x), y_pick(i));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule